// File: doc/BRIEF.md
# Serial Transmitter with Sixteenth-Bit Stop Control

This block serializes one character at a time onto an asynchronous line that idles high. Each frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional even or odd parity bit, then a high stop period. The stop period is programmed with a 4-bit code in steps of one sixteenth of a bit. The usable range depends on the character length.

Time advances only on a tick enable. In the normal mode that enable comes at 16 times the bit rate, so each bit lasts 16 ticks. In the alternative mode each tick is a whole bit, and the stop code then chooses only between one and two stop bits. A character is offered with a valid/ready handshake. Its length, parity and stop settings are captured at that moment, so the upstream logic may change them while the frame is being sent. If another character is waiting when the stop period ends, its start bit follows with no idle gap.

Top module: `uart_frac_tx`

## Requirements
- R1: While reset is asserted and right after it, `txLine` is 1, `txIdle` is 1 and `dataReady` is 1.
- R2: A character is taken on a clock edge where `dataValid` and `dataReady` are both 1. `dataReady` is 1 only when the transmitter is idle, or on the final tick of a stop period. `txIdle` is 1 exactly when no frame is in progress.
- R3: On the clock edge that takes a character, the line goes low for the start bit. The start bit lasts 16 ticks in 16X mode and 1 tick in 1X mode.
- R4: `charLen` selects 5, 6, 7 or 8 data bits for the codes 0, 1, 2 and 3. The data bits follow the start bit, least significant bit first, and each lasts one bit time.
- R5: When `parityEn` is 1, one parity bit follows the last data bit. With `parityOdd` = 0 the number of ones in the data bits plus the parity bit is even. With `parityOdd` = 1 that number is odd.
- R6: In 16X mode with 6, 7 or 8 data bits, stop codes 0 to 7 hold the line high for 9 + code ticks. This covers 9/16 to 1 bit.
- R7: In 16X mode with 6, 7 or 8 data bits, stop codes 8 to 15 hold the line high for 17 + code ticks. This covers 1 9/16 to 2 bits.
- R8: In 16X mode with 5 data bits, stop code n holds the line high for 17 + n ticks. This covers 1 1/16 to 2 bits.
- R9: When `oneXMode` is 1, every bit lasts one tick. Bit 3 of the stop code selects one stop bit when it is 0 and two stop bits when it is 1. Bits 2 to 0 of the code have no effect.
- R10: If a character is offered on the final stop tick, its start bit begins on the next clock with no idle cycle in between.
- R11: On a clock edge with `tickEn` = 0 that takes no character, `txLine` does not change.
- R12: The character length, parity, stop code and mode that apply to a frame are the values present when the frame was taken. Changes made during the frame do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Bit-time enable: the 16X tick, or the 1X bit clock in 1X mode |
| dataIn | input | 8 | Character to send |
| dataValid | input | 1 | A character is offered |
| dataReady | output | 1 | The transmitter takes the offered character on this edge |
| charLen | input | 2 | Data bit count: 0 = 5, 1 = 6, 2 = 7, 3 = 8 |
| parityEn | input | 1 | Append a parity bit |
| parityOdd | input | 1 | Parity sense: 0 = even, 1 = odd |
| stopCode | input | 4 | Stop length code |
| oneXMode | input | 1 | 1 = one tick per bit, whole stop bits only |
| txLine | output | 1 | Serial output, idles high |
| txIdle | output | 1 | No frame in progress |

## Verification
The frame is tried with every character length, with and without parity of either sense, and with stop codes on both sides of the code-8 boundary. This separates the three stop-length formulas and shows an off-by-one at either end of a range. A tick enable on every cycle gives exact frame lengths in clock cycles. Sparse ticks show whether the line waits for the enable or runs on the clock. 1X mode shows whether the low code bits are ignored there. A character offered on the final stop tick shows whether an idle cycle appears between frames. Changing the settings in the middle of a frame shows whether they were captured when the character was taken.

// File: rtl/uart_frac_tx_pkg.sv
package uart_frac_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } txState_t;

  // Which source the serial line is driven from
  typedef enum logic [1:0] {
    LINE_MARK,
    LINE_SPACE,
    LINE_DATA,
    LINE_PAR
  } lineSel_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic     load;
    logic     shift;
    lineSel_t lineSel;
  } txStrobe_t;

endpackage

// File: rtl/uart_tx_dp.sv
module uart_tx_dp
  import uart_frac_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVERSAMPLE = 16,
  parameter int CNT_W = 6,
  parameter int BIT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [1:0]        charLen,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic [3:0]        stopCode,
  input  logic              oneXMode,
  output logic              txLine,
  output logic [BIT_W-1:0]  nBits,
  output logic              parOn,
  output logic [CNT_W-1:0]  bitTicks,
  output logic [CNT_W-1:0]  stopTicks
);

  localparam int MIN_BITS = 5;
  localparam int HALF_OS = OVERSAMPLE / 2;

  logic [DATA_W-1:0] shiftReg;
  logic              parBit;
  logic [1:0]        cfgLen;
  logic              cfgPar;
  logic              cfgOneX;
  logic [3:0]        cfgStop;

  // Parity over the data bits actually sent in the new frame
  logic [DATA_W-1:0] usedBits;
  logic              newParity;
  int                newCount;

  always_comb begin
    newCount = MIN_BITS + int'(charLen);
    for (int i = 0; i < DATA_W; i++) begin
      usedBits[i] = dataIn[i] & (i < newCount);
    end
    newParity = (^usedBits) ^ parityOdd;
  end

  // Configuration is captured together with the character
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
      cfgLen   <= '0;
      cfgPar   <= 1'b0;
      cfgOneX  <= 1'b0;
      cfgStop  <= '0;
    end else if (strobe.load) begin
      shiftReg <= dataIn;
      parBit   <= newParity;
      cfgLen   <= charLen;
      cfgPar   <= parityEn;
      cfgOneX  <= oneXMode;
      cfgStop  <= stopCode;
    end else if (strobe.shift) begin
      shiftReg <= shiftReg >> 1;
    end
  end

  assign nBits    = BIT_W'(MIN_BITS) + BIT_W'(cfgLen);
  assign parOn    = cfgPar;
  assign bitTicks = cfgOneX ? CNT_W'(1) : CNT_W'(OVERSAMPLE);

  // Short range only for longer characters with a low code
  always_comb begin
    if (cfgOneX) begin
      stopTicks = cfgStop[3] ? CNT_W'(2) : CNT_W'(1);
    end else if (cfgLen == 2'd0 || cfgStop[3]) begin
      stopTicks = CNT_W'(OVERSAMPLE + 1) + CNT_W'(cfgStop);
    end else begin
      stopTicks = CNT_W'(HALF_OS + 1) + CNT_W'(cfgStop);
    end
  end

  always_comb begin
    unique case (strobe.lineSel)
      LINE_SPACE: txLine = 1'b0;
      LINE_DATA:  txLine = shiftReg[0];
      LINE_PAR:   txLine = parBit;
      default:    txLine = 1'b1;
    endcase
  end

endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_frac_tx_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int BIT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             dataValid,
  input  logic [BIT_W-1:0] nBits,
  input  logic             parOn,
  input  logic [CNT_W-1:0] bitTicks,
  input  logic [CNT_W-1:0] stopTicks,
  output logic             dataReady,
  output logic             txIdle,
  output txStrobe_t        strobe
);

  txState_t         state, stateNext;
  logic [CNT_W-1:0] tickCnt, cntNext;
  logic [BIT_W-1:0] bitIdx, idxNext;
  logic [CNT_W-1:0] curLen;
  logic             lastTick;
  logic             accept;

  assign curLen    = (state == ST_STOP) ? stopTicks : bitTicks;
  assign lastTick  = tickEn && (tickCnt == curLen - CNT_W'(1));
  assign dataReady = (state == ST_IDLE) || ((state == ST_STOP) && lastTick);
  assign accept    = dataValid && dataReady;
  assign txIdle    = (state == ST_IDLE);

  always_comb begin
    stateNext    = state;
    cntNext      = tickCnt;
    idxNext      = bitIdx;
    strobe.load  = accept;
    strobe.shift = 1'b0;
    if (tickEn && state != ST_IDLE) begin
      cntNext = lastTick ? '0 : tickCnt + CNT_W'(1);
    end
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          stateNext = ST_START;
          cntNext   = '0;
        end
      end
      ST_START: begin
        if (lastTick) begin
          stateNext = ST_DATA;
          idxNext   = '0;
        end
      end
      ST_DATA: begin
        if (lastTick) begin
          strobe.shift = 1'b1;
          if (bitIdx == nBits - BIT_W'(1)) begin
            stateNext = parOn ? ST_PARITY : ST_STOP;
          end else begin
            idxNext = bitIdx + BIT_W'(1);
          end
        end
      end
      ST_PARITY: begin
        if (lastTick) stateNext = ST_STOP;
      end
      ST_STOP: begin
        if (lastTick) stateNext = accept ? ST_START : ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state)
      ST_START:  strobe.lineSel = LINE_SPACE;
      ST_DATA:   strobe.lineSel = LINE_DATA;
      ST_PARITY: strobe.lineSel = LINE_PAR;
      default:   strobe.lineSel = LINE_MARK;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else begin
      state   <= stateNext;
      tickCnt <= cntNext;
      bitIdx  <= idxNext;
    end
  end

endmodule

// File: rtl/uart_frac_tx.sv
module uart_frac_tx
  import uart_frac_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              dataValid,
  output logic              dataReady,
  input  logic [1:0]        charLen,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic [3:0]        stopCode,
  input  logic              oneXMode,
  output logic              txLine,
  output logic              txIdle
);

  localparam int CNT_W = $clog2(2 * OVERSAMPLE + 1);
  localparam int BIT_W = $clog2(DATA_W + 1);

  txStrobe_t        strobe;
  logic [BIT_W-1:0] nBits;
  logic             parOn;
  logic [CNT_W-1:0] bitTicks;
  logic [CNT_W-1:0] stopTicks;

  uart_tx_ctrl #(.CNT_W(CNT_W), .BIT_W(BIT_W)) ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .dataValid(dataValid),
    .nBits(nBits), .parOn(parOn), .bitTicks(bitTicks), .stopTicks(stopTicks),
    .dataReady(dataReady), .txIdle(txIdle), .strobe(strobe)
  );

  uart_tx_dp #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE), .CNT_W(CNT_W), .BIT_W(BIT_W)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataIn(dataIn),
    .charLen(charLen), .parityEn(parityEn), .parityOdd(parityOdd),
    .stopCode(stopCode), .oneXMode(oneXMode), .txLine(txLine),
    .nBits(nBits), .parOn(parOn), .bitTicks(bitTicks), .stopTicks(stopTicks)
  );

endmodule

// File: rtl/uart_frac_tx_chk.sv
module uart_frac_tx_chk (
  input logic clk,
  input logic rstN,
  input logic tickEn,
  input logic dataValid,
  input logic dataReady,
  input logic txLine,
  input logic txIdle
);

  // R2: an idle transmitter always offers to take a character
  a_r2_idle_ready: assert property (@(posedge clk) disable iff (!rstN)
    txIdle |-> dataReady);

  // R2: a taken character makes the transmitter busy
  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && dataReady) |=> !txIdle);

  // R3: the start bit follows the handshake at once
  a_r3_start_low: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && dataReady) |=> !txLine);

  // R2: the idle line is high
  a_r2_idle_mark: assert property (@(posedge clk) disable iff (!rstN)
    txIdle |-> txLine);

  // R11: no tick and no handshake leaves the line untouched
  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !(dataValid && dataReady)) |=> $stable(txLine));

endmodule

bind uart_frac_tx uart_frac_tx_chk chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .dataValid(dataValid),
  .dataReady(dataReady), .txLine(txLine), .txIdle(txIdle)
);

// File: tb/tb_uart_frac_tx.sv
module tb_uart_frac_tx;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic [7:0] dataIn = '0;
  logic       dataValid = 1'b0;
  logic [1:0] charLen = 2'd3;
  logic       parityEn = 1'b0;
  logic       parityOdd = 1'b0;
  logic [3:0] stopCode = '0;
  logic       oneXMode = 1'b0;
  logic       dataReady, txLine, txIdle;

  uart_frac_tx dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .dataIn(dataIn),
    .dataValid(dataValid), .dataReady(dataReady), .charLen(charLen),
    .parityEn(parityEn), .parityOdd(parityOdd), .stopCode(stopCode),
    .oneXMode(oneXMode), .txLine(txLine), .txIdle(txIdle)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int tickDiv = 1;
  int cyc = 0;
  bit watchIdle = 0;
  int idleSeen = 0;

  always @(negedge clk) begin
    cyc++;
    tickEn <= (tickDiv <= 1) ? 1'b1 : ((cyc % tickDiv) == 0);
  end

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Reference model: queue of expected line levels, one per tick
  logic  mq[$];
  string tq[$];
  logic  mAcc;
  logic  edgeTick, edgeAcc;

  function automatic int stopLen(int n, int code, bit ox);
    if (ox) return (code >= 8) ? 2 : 1;
    if (n == 5 || code >= 8) return 17 + code;
    return 9 + code;
  endfunction

  function automatic int frameLen(int n, bit pe, int code, bit ox);
    int bt = ox ? 1 : 16;
    return bt * (1 + n + (pe ? 1 : 0)) + stopLen(n, code, ox);
  endfunction

  task automatic pushFrame();
    int n = 5 + int'(charLen);
    int bt = oneXMode ? 1 : 16;
    logic par = parityOdd;
    string st;
    for (int i = 0; i < n; i++) par = par ^ dataIn[i];
    for (int k = 0; k < bt; k++) begin mq.push_back(1'b0); tq.push_back(oneXMode ? "R9" : "R3"); end
    for (int i = 0; i < n; i++)
      for (int k = 0; k < bt; k++) begin mq.push_back(dataIn[i]); tq.push_back(oneXMode ? "R9" : "R4"); end
    if (parityEn)
      for (int k = 0; k < bt; k++) begin mq.push_back(par); tq.push_back(oneXMode ? "R9" : "R5"); end
    st = oneXMode ? "R9" : (n == 5) ? "R8" : (stopCode >= 8) ? "R7" : "R6";
    for (int k = 0; k < stopLen(n, int'(stopCode), oneXMode); k++) begin
      mq.push_back(1'b1); tq.push_back(st);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mq.delete(); tq.delete();
      edgeTick = 1'b1; edgeAcc = 1'b0;
    end else begin
      mAcc = dataValid && (mq.size() == 0 || (mq.size() == 1 && tickEn));
      edgeTick = tickEn;
      edgeAcc = mAcc;
      if (tickEn && mq.size() > 0) begin
        void'(mq.pop_front()); void'(tq.pop_front());
      end
      if (mAcc) pushFrame();
    end
  end

  // Per-cycle comparison, away from the active edge
  logic prevLine = 1'b1;
  always begin
    @(negedge clk);
    #1;
    if (rstN) begin
      logic expLine;
      logic expReady;
      expLine  = (mq.size() > 0) ? mq[0] : 1'b1;
      expReady = (mq.size() == 0) || (mq.size() == 1 && tickEn);
      chk(txLine === expLine, (mq.size() > 0) ? tq[0] : "R2", "txLine", txLine, expLine);
      chk(txIdle === (mq.size() == 0), "R2", "txIdle", txIdle, mq.size() == 0);
      chk(dataReady === expReady, "R2", "dataReady", dataReady, expReady);
      if (!edgeTick && !edgeAcc)
        chk(txLine === prevLine, "R11", "line held without tick", txLine, prevLine);
      if (watchIdle && txIdle) idleSeen++;
      prevLine = txLine;
    end
  end

  task automatic setCfg(int len, bit pe, bit po, int code, bit ox);
    @(negedge clk);
    charLen = 2'(len - 5); parityEn = pe; parityOdd = po;
    stopCode = 4'(code); oneXMode = ox;
  endtask

  // Offers a byte and returns just after the accepting edge
  task automatic offer(logic [7:0] d);
    bit done = 0;
    @(negedge clk);
    dataIn = d; dataValid = 1'b1;
    while (!done) begin
      #1;
      if (dataReady) begin
        @(posedge clk);
        done = 1;
      end else begin
        @(negedge clk);
      end
    end
  endtask

  // Sends one byte and returns the number of busy cycles
  task automatic sendMeasure(logic [7:0] d, output int c);
    offer(d);
    @(negedge clk);
    dataValid = 1'b0;
    #1;
    c = 0;
    while (!txIdle) begin
      c++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic waitIdle();
    @(negedge clk); #1;
    while (!txIdle) begin @(negedge clk); #1; end
  endtask

  initial begin
    int c;
    repeat (3) @(negedge clk);
    #1;
    chk(txLine === 1'b1, "R1", "reset line", txLine, 1);
    chk(txIdle === 1'b1, "R1", "reset idle", txIdle, 1);
    chk(dataReady === 1'b1, "R1", "reset ready", dataReady, 1);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(txLine === 1'b1 && txIdle === 1'b1, "R1", "after reset", txLine, 1);

    tickDiv = 1;
    setCfg(8, 0, 0, 0, 0);
    sendMeasure(8'hA5, c);
    chk(c == frameLen(8, 0, 0, 0), "R6", "frame 8N code0", c, frameLen(8, 0, 0, 0));
    setCfg(8, 0, 0, 7, 0);
    sendMeasure(8'h01, c);
    chk(c == frameLen(8, 0, 7, 0), "R6", "frame 8N code7", c, frameLen(8, 0, 7, 0));
    setCfg(5, 1, 0, 15, 0);
    sendMeasure(8'h1B, c);
    chk(c == frameLen(5, 1, 15, 0), "R8", "frame 5E code15", c, frameLen(5, 1, 15, 0));
    setCfg(5, 0, 0, 0, 0);
    sendMeasure(8'hFF, c);
    chk(c == frameLen(5, 0, 0, 0), "R8", "frame 5N code0", c, frameLen(5, 0, 0, 0));
    setCfg(7, 1, 1, 8, 0);
    sendMeasure(8'h6D, c);
    chk(c == frameLen(7, 1, 8, 0), "R7", "frame 7O code8", c, frameLen(7, 1, 8, 0));
    setCfg(6, 1, 1, 7, 0);
    sendMeasure(8'h2A, c);
    chk(c == frameLen(6, 1, 7, 0), "R6", "frame 6O code7", c, frameLen(6, 1, 7, 0));

    // 1X mode: low code bits ignored
    setCfg(8, 1, 0, 7, 1);
    sendMeasure(8'hC3, c);
    chk(c == 11, "R9", "1X code7 one stop", c, 11);
    setCfg(8, 1, 0, 8, 1);
    sendMeasure(8'h3C, c);
    chk(c == 12, "R9", "1X code8 two stops", c, 12);

    // Sparse ticks
    tickDiv = 3;
    setCfg(8, 1, 0, 3, 0);
    offer(8'h96);
    @(negedge clk); dataValid = 1'b0;
    waitIdle();
    tickDiv = 4;
    setCfg(6, 0, 0, 12, 0);
    offer(8'h15);
    @(negedge clk); dataValid = 1'b0;
    waitIdle();

    // Back-to-back frames
    tickDiv = 1;
    setCfg(7, 0, 0, 2, 0);
    offer(8'h55);
    watchIdle = 1; idleSeen = 0;
    @(negedge clk);
    offer(8'h2A);
    watchIdle = 0;
    chk(idleSeen == 0, "R10", "idle cycles between frames", idleSeen, 0);
    @(negedge clk); dataValid = 1'b0;
    waitIdle();

    // Settings changed mid-frame
    setCfg(8, 0, 0, 5, 0);
    offer(8'hF0);
    @(negedge clk);
    dataValid = 1'b0;
    charLen = 2'd0; parityEn = 1'b1; parityOdd = 1'b1; stopCode = 4'd12; oneXMode = 1'b1;
    #1;
    c = 0;
    while (!txIdle) begin c++; @(negedge clk); #1; end
    chk(c == frameLen(8, 0, 5, 0), "R12", "frame uses captured settings", c, frameLen(8, 0, 5, 0));

    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule